// File: doc/BRIEF.md
# Crypto Descriptor Chain Engine

This block walks a linked list of packet descriptors on behalf of one crypto channel. Software starts it by writing a descriptor address into the pointer register. The engine then reads the sixteen-word descriptor in one burst. Before touching any data, it reserves the execution units that the header names. It then issues one data-move request for every length/pointer pair whose length is non-zero, one request at a time and in pair order.

When a descriptor's last transfer is acknowledged, the engine releases the reservation. It can then report completion in two ways: by writing the header back with its done bit set, and by pulsing an interrupt. A configuration input chooses whether completion is reported after every descriptor or only after the last descriptor of a chain. The engine then follows the link word. A non-zero link starts the next fetch, and a zero link returns the engine to idle.

The execution units, the bus arbitration and the data movement itself are outside the block. They appear only as handshakes on a reservation port, a transfer port, a burst read port and a write-back port.

Top module: `desc_chain_engine`

## Requirements
- R1: While the engine is idle, a pulse on `ptr_wr_i` starts it. It raises `rd_req_o` with `rd_addr_o` equal to `ptr_wdata_i` and holds both until `rd_ack_i`. It then captures sixteen `rd_valid_i` beats.
- R2: Descriptor layout, in 32-bit words: word 0 is the header. Word 2p+1 is the byte length of pair p and word 2p+2 is the start address of pair p, for p = 0..6. Word 15 is the link to the next descriptor.
- R3: After the fetch and before any transfer, `rsv_req_o` rises with `rsv_units_o` equal to header bits 7:4. No transfer is issued until `rsv_gnt_i` is seen. `rsv_req_o` stays high until the last transfer of the descriptor is acknowledged, then drops. It is raised again once for each descriptor.
- R4: One transfer is issued for each pair with a non-zero length, in ascending pair order. `xfer_len_o` and `xfer_addr_o` carry that pair's length and address and stay stable until `xfer_ack_i`.
- R5: A pair whose length is zero produces no transfer. A descriptor whose lengths are all zero completes without any transfer.
- R6: After a descriptor completes, a non-zero link word starts a burst read at that address, and a zero link returns the engine to idle (`busy_o` low).
- R7: When `cfg_chain_done_i` is 0, completion is reported after every descriptor. When it is 1, completion is reported only after the descriptor whose link is zero.
- R8: At each reported completion with `cfg_wb_en_i` high, the engine writes the fetched header with bit 0 (the done bit) set to 1 back to that descriptor's own address. It does this before it follows the link.
- R9: At each reported completion with `cfg_irq_en_i` high, `irq_o` pulses high for exactly one cycle.
- R10: A `ptr_wr_i` pulse while `busy_o` is high is ignored: the chain being walked is unchanged. The pulse sets the sticky flag `err_o`, which stays high until `err_clr_i` is pulsed.
- R11: After reset, `busy_o`, `err_o`, `irq_o` and all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_wr_i | input | 1 | Pointer register write strobe |
| ptr_wdata_i | input | 32 | Address of the first descriptor |
| cfg_chain_done_i | input | 1 | 1: report completion only at the end of the chain |
| cfg_wb_en_i | input | 1 | Enable header write-back on completion |
| cfg_irq_en_i | input | 1 | Enable the interrupt pulse on completion |
| err_clr_i | input | 1 | Clears the sticky error flag |
| busy_o | output | 1 | Engine is walking a chain |
| err_o | output | 1 | Sticky flag: pointer was written while busy |
| irq_o | output | 1 | One-cycle completion interrupt |
| rd_req_o | output | 1 | Burst read request |
| rd_addr_o | output | 32 | Burst start address |
| rd_ack_i | input | 1 | Burst read request accepted |
| rd_valid_i | input | 1 | Read data beat valid |
| rd_data_i | input | 32 | Read data beat |
| rsv_req_o | output | 1 | Execution unit reservation request, held while reserved |
| rsv_units_o | output | 4 | Execution units to reserve |
| rsv_gnt_i | input | 1 | Reservation granted |
| xfer_req_o | output | 1 | Data-move request |
| xfer_len_o | output | 32 | Byte length of the move |
| xfer_addr_o | output | 32 | Start address of the move |
| xfer_ack_i | input | 1 | Data-move request accepted |
| wb_req_o | output | 1 | Header write-back request |
| wb_addr_o | output | 32 | Write-back address |
| wb_data_o | output | 32 | Header with the done bit set |
| wb_ack_i | input | 1 | Write-back accepted |

## Verification
The assertions check the following on every cycle:
- request stability on the read and transfer ports;
- no transfer without a held reservation, and no zero-length transfer;
- strictly ascending pair order;
- that a link fetch goes to the link address;
- the single-cycle interrupt pulse, the done bit in write-back data, and the stickiness of the error flag.

Only the bench's scenarios can show that the set of transfers matches the descriptor contents, since that needs knowledge of the memory image. The same holds for the number of reservations, write-backs and interrupts under each completion mode, for the addresses of every fetch along a chain, and for the fact that a write while busy leaves the chain untouched.

// File: rtl/desc_chain_pkg.sv
package desc_chain_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_LOAD, S_RSV, S_ISSUE, S_WB, S_LINK
  } dce_state_e;
endpackage

// File: rtl/dce_desc_buf.sv
module dce_desc_buf #(
  parameter int DW     = 32,
  parameter int NWORDS = 16,
  parameter int BW     = $clog2(NWORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] words_o [NWORDS],
  output logic          last_o
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < NWORDS; i++) words_o[i] <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (valid_i) begin
      words_o[cnt_q] <= data_i;
      cnt_q          <= cnt_q + 1'b1;
    end
  end

  assign last_o = valid_i && (cnt_q == BW'(NWORDS - 1));

  // beats only arrive after the request phase has ended
  p_no_beat_in_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !clr_i);
endmodule

// File: rtl/dce_pair_scan.sv
module dce_pair_scan #(
  parameter int NPAIRS = 7,
  parameter int IW     = $clog2(NPAIRS)
) (
  input  logic [NPAIRS-1:0] mask_i,
  output logic [IW-1:0]     idx_o,
  output logic              any_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int p = NPAIRS - 1; p >= 0; p--) begin
      if (mask_i[p]) begin
        idx_o = IW'(p);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/desc_chain_engine.sv
module desc_chain_engine
  import desc_chain_pkg::*;
#(
  parameter int DW       = 32,
  parameter int NPAIRS   = 7,
  parameter int UNIT_W   = 4,
  parameter int UNIT_LSB = 4,
  parameter int DONE_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_wr_i,
  input  logic [DW-1:0]     ptr_wdata_i,
  input  logic              cfg_chain_done_i,
  input  logic              cfg_wb_en_i,
  input  logic              cfg_irq_en_i,
  input  logic              err_clr_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              rd_req_o,
  output logic [DW-1:0]     rd_addr_o,
  input  logic              rd_ack_i,
  input  logic              rd_valid_i,
  input  logic [DW-1:0]     rd_data_i,
  output logic              rsv_req_o,
  output logic [UNIT_W-1:0] rsv_units_o,
  input  logic              rsv_gnt_i,
  output logic              xfer_req_o,
  output logic [DW-1:0]     xfer_len_o,
  output logic [DW-1:0]     xfer_addr_o,
  input  logic              xfer_ack_i,
  output logic              wb_req_o,
  output logic [DW-1:0]     wb_addr_o,
  output logic [DW-1:0]     wb_data_o,
  input  logic              wb_ack_i
);
  localparam int NWORDS = 2 * NPAIRS + 2;
  localparam int IW     = $clog2(NPAIRS);

  dce_state_e        state_q, state_d;
  logic [DW-1:0]     cur_ptr_q;
  logic [NPAIRS-1:0] pend_q, pend_d, nz_mask, pend_left;
  logic [DW-1:0]     words [NWORDS];
  logic              last_beat, scan_any, report, last_ack;
  logic [IW-1:0]     scan_idx;
  logic [DW-1:0]     hdr, link;

  dce_desc_buf #(.DW(DW), .NWORDS(NWORDS)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == S_FETCH),
    .valid_i (rd_valid_i && state_q == S_LOAD),
    .data_i  (rd_data_i),
    .words_o (words),
    .last_o  (last_beat)
  );

  assign hdr  = words[0];
  assign link = words[NWORDS-1];

  for (genvar p = 0; p < NPAIRS; p++) begin : g_nz
    assign nz_mask[p] = |words[2*p+1];
  end

  dce_pair_scan #(.NPAIRS(NPAIRS)) u_scan (
    .mask_i (pend_q),
    .idx_o  (scan_idx),
    .any_o  (scan_any)
  );

  assign pend_left = pend_q & ~(NPAIRS'(1) << scan_idx);
  assign last_ack  = xfer_ack_i && (pend_left == '0);
  assign report    = !cfg_chain_done_i || (link == '0);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      S_IDLE:  if (ptr_wr_i) state_d = S_FETCH;
      S_FETCH: if (rd_ack_i) state_d = S_LOAD;
      S_LOAD:  if (last_beat) state_d = S_RSV;
      S_RSV: if (rsv_gnt_i) begin
        pend_d = nz_mask;
        if (nz_mask == '0) state_d = (report && cfg_wb_en_i) ? S_WB : S_LINK;
        else               state_d = S_ISSUE;
      end
      S_ISSUE: if (xfer_ack_i) begin
        pend_d = pend_left;
        if (last_ack) state_d = (report && cfg_wb_en_i) ? S_WB : S_LINK;
      end
      S_WB:    if (wb_ack_i) state_d = S_LINK;
      S_LINK:  state_d = (link != '0) ? S_FETCH : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      pend_q    <= '0;
      cur_ptr_q <= '0;
      err_o     <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (state_q == S_IDLE && ptr_wr_i) cur_ptr_q <= ptr_wdata_i;
      else if (state_q == S_LINK && link != '0) cur_ptr_q <= link;
      if (ptr_wr_i && state_q != S_IDLE) err_o <= 1'b1;
      else if (err_clr_i)                err_o <= 1'b0;
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign rd_req_o    = (state_q == S_FETCH);
  assign rd_addr_o   = cur_ptr_q;
  assign rsv_req_o   = (state_q == S_RSV) || (state_q == S_ISSUE);
  assign rsv_units_o = hdr[UNIT_LSB +: UNIT_W];
  assign xfer_req_o  = (state_q == S_ISSUE) && scan_any;
  assign xfer_len_o  = words[2*scan_idx+1];
  assign xfer_addr_o = words[2*scan_idx+2];
  assign wb_req_o    = (state_q == S_WB);
  assign wb_addr_o   = cur_ptr_q;
  assign wb_data_o   = hdr | (DW'(1) << DONE_BIT);
  assign irq_o       = (state_q == S_LINK) && report && cfg_irq_en_i;

  p_rd_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  p_xfer_rsv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> rsv_req_o);
  p_rsv_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rsv_req_o) |-> (state_q == S_WB || state_q == S_LINK));
  p_xfer_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_ack_i |=> xfer_req_o && $stable(xfer_len_o) && $stable(xfer_addr_o));
  p_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && xfer_ack_i |=> !xfer_req_o || (scan_idx > $past(scan_idx)));
  p_no_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> xfer_len_o != '0);
  p_fetch_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_LINK && link != '0 |=> rd_req_o && rd_addr_o == $past(link));
  p_wb_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_req_o |-> wb_data_o[DONE_BIT]);
  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_busy_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && ptr_wr_i |=> err_o);
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o);
endmodule

// File: tb/desc_chain_engine_bench.sv
module desc_chain_engine_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ptr_wr_i = 1'b0;
  logic [31:0] ptr_wdata_i = '0;
  logic        cfg_chain_done_i = 1'b0, cfg_wb_en_i = 1'b0, cfg_irq_en_i = 1'b0;
  logic        err_clr_i = 1'b0;
  logic        busy_o, err_o, irq_o;
  logic        rd_req_o, rd_ack_i = 1'b0, rd_valid_i = 1'b0;
  logic [31:0] rd_addr_o, rd_data_i = '0;
  logic        rsv_req_o, rsv_gnt_i = 1'b0;
  logic [3:0]  rsv_units_o;
  logic        xfer_req_o, xfer_ack_i = 1'b0;
  logic [31:0] xfer_len_o, xfer_addr_o;
  logic        wb_req_o, wb_ack_i = 1'b0;
  logic [31:0] wb_addr_o, wb_data_o;

  always #4 clk = ~clk;

  desc_chain_engine u_desc_chain_engine (
    .clk_i(clk), .rst_ni(rst_ni), .ptr_wr_i(ptr_wr_i), .ptr_wdata_i(ptr_wdata_i),
    .cfg_chain_done_i(cfg_chain_done_i), .cfg_wb_en_i(cfg_wb_en_i),
    .cfg_irq_en_i(cfg_irq_en_i), .err_clr_i(err_clr_i), .busy_o(busy_o),
    .err_o(err_o), .irq_o(irq_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .rsv_req_o(rsv_req_o), .rsv_units_o(rsv_units_o), .rsv_gnt_i(rsv_gnt_i),
    .xfer_req_o(xfer_req_o), .xfer_len_o(xfer_len_o), .xfer_addr_o(xfer_addr_o),
    .xfer_ack_i(xfer_ack_i), .wb_req_o(wb_req_o), .wb_addr_o(wb_addr_o),
    .wb_data_o(wb_data_o), .wb_ack_i(wb_ack_i)
  );

  int vecs = 0, miss = 0;
  logic [31:0] mem [0:511];

  // observation records
  int          n_xf, n_wb, n_irq, n_rsv, n_fetch;
  logic [31:0] ob_len [0:63], ob_addr [0:63], ob_wba [0:7], ob_wbd [0:7], ob_fetch [0:7];
  logic [3:0]  ob_unit [0:63];
  logic        ob_rsv [0:63];
  logic        rsv_prev = 1'b0;

  int chain_wa [0:3];
  int chain_n;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // burst read responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_o && !rd_ack_i) begin
        int base;
        base = int'(rd_addr_o[10:2]);
        if (n_fetch < 8) ob_fetch[n_fetch] = rd_addr_o;
        n_fetch++;
        rd_ack_i = 1'b1;
        @(negedge clk);
        rd_ack_i = 1'b0;
        for (int k = 0; k < 16; k++) begin
          rd_valid_i = 1'b1;
          rd_data_i  = mem[base + k];
          @(negedge clk);
        end
        rd_valid_i = 1'b0;
      end
    end
  end

  // reservation, transfer, write-back responders and irq monitor
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      rsv_gnt_i = rsv_req_o;
      if (rsv_req_o && !rsv_prev) n_rsv++;
      rsv_prev = rsv_req_o;
      if (irq_o) n_irq++;
      xfer_ack_i = 1'b0;
      if (xfer_req_o) begin
        ph++;
        if (ph % 3 != 1) begin
          xfer_ack_i = 1'b1;
          if (n_xf < 64) begin
            ob_len[n_xf]  = xfer_len_o;
            ob_addr[n_xf] = xfer_addr_o;
            ob_unit[n_xf] = rsv_units_o;
            ob_rsv[n_xf]  = rsv_req_o;
          end
          n_xf++;
        end
      end
      wb_ack_i = 1'b0;
      if (wb_req_o) begin
        wb_ack_i = 1'b1;
        if (n_wb < 8) begin
          ob_wba[n_wb] = wb_addr_o;
          ob_wbd[n_wb] = wb_data_o;
        end
        n_wb++;
      end
    end
  end

  task automatic put_desc(input int wa, input logic [31:0] hdr, input logic [6:0] mask,
                          input int seed, input logic [31:0] nxt);
    mem[wa] = hdr;
    for (int p = 0; p < 7; p++) begin
      mem[wa+1+2*p] = mask[p] ? 32'((p + 1) * 4 + seed) : 32'd0;
      mem[wa+2+2*p] = 32'h4000_0000 + 32'(seed * 256 + p * 16);
    end
    mem[wa+15] = nxt;
  endtask

  task automatic run_chain(input logic [2:0] cfg, input bit bad_write);
    int k, w, exp_wb, exp_irq, guard;
    cfg_chain_done_i = cfg[2];
    cfg_wb_en_i      = cfg[1];
    cfg_irq_en_i     = cfg[0];
    n_xf = 0; n_wb = 0; n_irq = 0; n_rsv = 0; n_fetch = 0;
    @(negedge clk);
    ptr_wr_i = 1'b1;
    ptr_wdata_i = 32'(chain_wa[0] * 4);
    @(negedge clk);
    ptr_wr_i = 1'b0;
    chk("R1 rd_req after start", 32'(rd_req_o), 32'd1);
    chk("R1 rd_addr", rd_addr_o, 32'(chain_wa[0] * 4));
    if (bad_write) begin
      ptr_wr_i = 1'b1;
      ptr_wdata_i = 32'h0000_0400;
      @(negedge clk);
      ptr_wr_i = 1'b0;
      @(negedge clk);
      chk("R10 err set by busy write", 32'(err_o), 32'd1);
    end
    guard = 0;
    while (busy_o && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk("R6 idle at chain end", 32'(busy_o), 32'd0);
    chk("R3 reservation released", 32'(rsv_req_o), 32'd0);
    chk("R3 one reservation per descriptor", 32'(n_rsv), 32'(chain_n));
    chk("R6 fetch count", 32'(n_fetch), 32'(chain_n));
    for (int d = 0; d < chain_n && d < 8; d++)
      chk("R6 fetch address", ob_fetch[d], 32'(chain_wa[d] * 4));
    k = 0; w = 0; exp_wb = 0; exp_irq = 0;
    for (int d = 0; d < chain_n; d++) begin
      bit sig;
      for (int p = 0; p < 7; p++) begin
        if (mem[chain_wa[d]+1+2*p] != 0) begin
          if (k < 64) begin
            chk("R4 xfer length", ob_len[k], mem[chain_wa[d]+1+2*p]);
            chk("R4 xfer address", ob_addr[k], mem[chain_wa[d]+2+2*p]);
            chk("R3 units during xfer", 32'(ob_unit[k]), 32'(mem[chain_wa[d]][7:4]));
            chk("R3 rsv held during xfer", 32'(ob_rsv[k]), 32'd1);
          end
          k++;
        end
      end
      sig = !cfg[2] || (d == chain_n - 1);
      if (sig && cfg[1]) begin
        if (w < 8) begin
          chk("R8 wb address", ob_wba[w], 32'(chain_wa[d] * 4));
          chk("R8 wb data", ob_wbd[w], mem[chain_wa[d]] | 32'd1);
        end
        w++;
      end
      if (sig && cfg[0]) exp_irq++;
    end
    exp_wb = w;
    chk("R5 transfer count", 32'(n_xf), 32'(k));
    chk("R7 R8 writeback count", 32'(n_wb), 32'(exp_wb));
    chk("R7 R9 irq count", 32'(n_irq), 32'(exp_irq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 busy after reset", 32'(busy_o), 0);
    chk("R11 err after reset", 32'(err_o), 0);
    chk("R11 irq after reset", 32'(irq_o), 0);
    chk("R11 requests after reset",
        32'({rd_req_o, rsv_req_o, xfer_req_o, wb_req_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 idle after release", 32'(busy_o), 0);

    // R2 R4 R5: every pair-occupancy mask on a single descriptor
    for (int m = 0; m < 128; m++) begin
      put_desc(16, 32'h0000_3C00 | 32'((m & 15) << 4), 7'(m), m, 32'd0);
      chain_wa[0] = 16;
      chain_n = 1;
      run_chain(3'(m), 1'b0);
    end

    // R6 R7 R8 R9: chains of length 1..3 under every completion setting
    for (int n = 1; n <= 3; n++) begin
      for (int c = 0; c < 8; c++) begin
        for (int d = 0; d < n; d++) begin
          chain_wa[d] = 48 + 32 * d;
          put_desc(chain_wa[d], 32'h0000_1200 | 32'(((d * 5 + c) & 15) << 4),
                   7'(7'h55 >> d | 7'(c << d)), 3 * d + c,
                   (d == n - 1) ? 32'd0 : 32'((48 + 32 * (d + 1)) * 4));
        end
        chain_n = n;
        run_chain(3'(c), 1'b0);
      end
    end

    // R10: write while busy is ignored and latches the error flag
    for (int d = 0; d < 2; d++) begin
      chain_wa[d] = 200 + 32 * d;
      put_desc(chain_wa[d], 32'h0000_00A0, 7'h7F, d + 9,
               (d == 1) ? 32'd0 : 32'(232 * 4));
    end
    chain_n = 2;
    run_chain(3'b011, 1'b1);
    chk("R10 err stays set", 32'(err_o), 32'd1);
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
    @(negedge clk);
    chk("R10 err cleared", 32'(err_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule